// File: doc/BRIEF.md
# Degradable Two-out-of-Four Trip Voter

This block merges the partial trip decisions of four redundant protection channels into a single trip command. Each channel carries a measured plant parameter, which a per-channel bistable compares against that channel's trip setpoint. The comparison uses a hysteresis band, so the channel's demand bit does not chatter when the reading sits near the threshold. Each channel also carries a diagnosed-failed flag from external diagnostics.

The voting rule depends on how many channels are flagged as failed. With all four channels healthy, the block trips when any two of them demand it. With one channel failed, that channel's demand is dropped and the block trips on two of the three remaining channels. With two or more channels failed, the block trips whatever the demands are. A failure flag is latched and stays set until maintenance clears it.

Voting takes place on a calculation-cycle strobe, and the trip command and the active mode are registered on that strobe. The number of latched failed channels is reported continuously.

Top module: `trip_vote_top`

## Requirements
- R1: While reset is asserted and after its release, until the first strobe: trip_o = 1, mode_o = 2'b10 and fail_cnt_o = 0.
- R2: With no channel failed, a strobe sets trip_o to 1 when two or more channel demands are set, and to 0 otherwise.
- R3: With exactly one channel failed, that channel's demand is ignored. A strobe sets trip_o to 1 only when at least two of the other three channels demand a trip.
- R4: With two or more channels failed, a strobe sets trip_o to 1 and mode_o to 2'b10, whatever the channel demands are.
- R5: On a strobe, a channel demand becomes 1 when its measurement is greater than or equal to its setpoint.
- R6: On a strobe, a set channel demand clears only when its measurement is below the setpoint minus hyst_i. This release level saturates at 0. When the measurement lies between the release level and the setpoint, the demand keeps its previous value.
- R7: trip_o and mode_o change only on the clock edge at which cycle_stb_i is high. They take the new value in the following cycle. Measurements and flags seen on that strobe are used.
- R8: A high fail_flag_i bit latches that channel as failed on the next edge. The latch holds until an edge at which maint_clr_i is high and the flag is low. A flag that is still high wins over the clear. fail_cnt_o reports the number of latched channels one cycle after the flag.
- R9: mode_o is 2'b00 for two-of-four voting, 2'b01 for two-of-three voting and 2'b10 for forced trip. It never shows 2'b11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cycle_stb_i | input | 1 | Calculation-cycle strobe, one cycle wide |
| meas_i | input | NCH*W | Measured parameter per channel, channel 0 in the low bits |
| setp_i | input | NCH*W | Trip setpoint per channel, channel 0 in the low bits |
| hyst_i | input | W | Hysteresis band, shared by all channels |
| fail_flag_i | input | NCH | Diagnosed-failed flag per channel |
| maint_clr_i | input | 1 | Maintenance clear for the latched failures |
| trip_o | output | 1 | Registered trip command, 1 = trip |
| mode_o | output | 2 | Active voting mode code |
| fail_cnt_o | output | $clog2(NCH+1) | Number of latched failed channels |

## Verification
The assertions assume the following about the inputs: the strobe is a single-cycle pulse, and the setpoint and hysteresis inputs are steady in the cycle that a strobe samples. The demand-hold property compares one strobe's release window with the stored bit, so a change of setpoint in that cycle would break its premise. The stimulus follows these rules. It changes every input only on the falling clock edge. It raises the strobe for exactly one cycle. It sets the setpoints and the band once at the start. It pulses the failure flags or holds them across a clear, and never moves them within a strobe cycle.

// File: rtl/trip_vote_pkg.sv
package trip_vote_pkg;
  typedef enum logic [1:0] {
    MODE_2OF4   = 2'b00,
    MODE_2OF3   = 2'b01,
    MODE_FORCED = 2'b10
  } vote_mode_e;
endpackage

// File: rtl/trip_bistable.sv
module trip_bistable #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         stb_i,
  input  logic [W-1:0] meas_i,
  input  logic [W-1:0] setp_i,
  input  logic [W-1:0] hyst_i,
  output logic         dmd_next_o,
  output logic         dmd_o
);
  logic [W-1:0] rel_lvl;
  logic         dmd_q;

  always_comb begin
    rel_lvl = (setp_i > hyst_i) ? (setp_i - hyst_i) : '0;
    if (meas_i >= setp_i)      dmd_next_o = 1'b1;
    else if (meas_i < rel_lvl) dmd_next_o = 1'b0;
    else                       dmd_next_o = dmd_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    dmd_q <= 1'b0;
    else if (stb_i) dmd_q <= dmd_next_o;
  end

  assign dmd_o = dmd_q;

  assert_bistable_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_i && (meas_i >= setp_i) |=> dmd_q);

  assert_bistable_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_i && (meas_i < setp_i) && (meas_i >= rel_lvl) |=> dmd_q == $past(dmd_q));
endmodule

// File: rtl/fail_latch.sv
module fail_latch #(
  parameter int NCH = 4,
  localparam int CW = $clog2(NCH + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] flag_i,
  input  logic           clr_i,
  output logic [NCH-1:0] eff_o,
  output logic [CW-1:0]  cnt_o
);
  logic [NCH-1:0] failed_q;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) failed_q[g] <= 1'b0;
      else         failed_q[g] <= flag_i[g] | (failed_q[g] & ~clr_i);
    end

    assert_latch_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      failed_q[g] && !clr_i |=> failed_q[g]);

    assert_latch_capture_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flag_i[g] |=> failed_q[g]);
  end

  // a flag raised in the strobe cycle already takes part in that vote
  assign eff_o = failed_q | flag_i;
  assign cnt_o = CW'($countones(failed_q));
endmodule

// File: rtl/trip_voter.sv
module trip_voter
  import trip_vote_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int NEED = 2,
  localparam int CW  = $clog2(NCH + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           stb_i,
  input  logic [NCH-1:0] dmd_i,
  input  logic [NCH-1:0] fail_i,
  output logic           trip_o,
  output vote_mode_e     mode_o
);
  logic [CW-1:0] n_fail, n_live;
  logic          trip_d;
  vote_mode_e    mode_d;

  always_comb begin
    n_fail = CW'($countones(fail_i));
    n_live = CW'($countones(dmd_i & ~fail_i));
    if (n_fail == '0) begin
      mode_d = MODE_2OF4;
      trip_d = (n_live >= CW'(NEED));
    end else if (n_fail == CW'(1)) begin
      mode_d = MODE_2OF3;
      trip_d = (n_live >= CW'(NEED));
    end else begin
      mode_d = MODE_FORCED;
      trip_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trip_o <= 1'b1;
      mode_o <= MODE_FORCED;
    end else if (stb_i) begin
      trip_o <= trip_d;
      mode_o <= mode_d;
    end
  end

  assert_forced_trip_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_i && ($countones(fail_i) >= 2) |=> trip_o && (mode_o == MODE_FORCED));

  assert_healthy_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_i && (fail_i == '0) && ($countones(dmd_i) < NEED) |=> !trip_o);

  assert_healthy_trip_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_i && (fail_i == '0) && ($countones(dmd_i) >= NEED) |=> trip_o);

  assert_hold_between_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stb_i |=> $stable(trip_o) && $stable(mode_o));
endmodule

// File: rtl/trip_vote_top.sv
module trip_vote_top
  import trip_vote_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int W    = 12,
  parameter int NEED = 2,
  localparam int CW  = $clog2(NCH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cycle_stb_i,
  input  logic [NCH*W-1:0] meas_i,
  input  logic [NCH*W-1:0] setp_i,
  input  logic [W-1:0]     hyst_i,
  input  logic [NCH-1:0]   fail_flag_i,
  input  logic             maint_clr_i,
  output logic             trip_o,
  output logic [1:0]       mode_o,
  output logic [CW-1:0]    fail_cnt_o
);
  logic [NCH-1:0] dmd_next, dmd_held, fail_eff;
  vote_mode_e     mode_q;

  for (genvar g = 0; g < NCH; g++) begin : g_bis
    trip_bistable #(.W(W)) u_bis (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .stb_i      (cycle_stb_i),
      .meas_i     (meas_i[g*W +: W]),
      .setp_i     (setp_i[g*W +: W]),
      .hyst_i     (hyst_i),
      .dmd_next_o (dmd_next[g]),
      .dmd_o      (dmd_held[g])
    );
  end

  fail_latch #(.NCH(NCH)) u_fail (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .flag_i (fail_flag_i),
    .clr_i  (maint_clr_i),
    .eff_o  (fail_eff),
    .cnt_o  (fail_cnt_o)
  );

  trip_voter #(.NCH(NCH), .NEED(NEED)) u_vote (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .stb_i  (cycle_stb_i),
    .dmd_i  (dmd_next),
    .fail_i (fail_eff),
    .trip_o (trip_o),
    .mode_o (mode_q)
  );

  assign mode_o = mode_q;

  assert_mode_legal_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o != 2'b11);

  assert_vote_uses_stored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cycle_stb_i |=> dmd_held == $past(dmd_next));
endmodule

// File: tb/sim_trip_vote_top.sv
module sim_trip_vote_top;
  localparam int NCH = 4;
  localparam int W   = 12;
  localparam int CW  = $clog2(NCH + 1);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             stb = 1'b0;
  logic [NCH*W-1:0] meas = '0;
  logic [NCH*W-1:0] setp = '0;
  logic [W-1:0]     hyst = '0;
  logic [NCH-1:0]   flag = '0;
  logic             clr = 1'b0;
  logic             trip;
  logic [1:0]       mode;
  logic [CW-1:0]    fcnt;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  trip_vote_top #(.NCH(NCH), .W(W)) u0 (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .cycle_stb_i (stb),
    .meas_i      (meas),
    .setp_i      (setp),
    .hyst_i      (hyst),
    .fail_flag_i (flag),
    .maint_clr_i (clr),
    .trip_o      (trip),
    .mode_o      (mode),
    .fail_cnt_o  (fcnt)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_meas(input int a, input int b, input int c, input int d);
    meas = {W'(d), W'(c), W'(b), W'(a)};
  endtask

  // raise the strobe for one edge; return at the next falling edge
  task automatic strobe();
    stb = 1'b1;
    @(negedge clk);
    stb = 1'b0;
  endtask

  task automatic pulse_flag(input int ch);
    flag[ch] = 1'b1;
    @(negedge clk);
    flag[ch] = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 trip in reset", trip, 1);
    chk("R1 mode in reset", mode, 2);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 trip after release", trip, 1);
    chk("R1 mode after release", mode, 2);
    chk("R1 fail count", fcnt, 0);
  endtask

  task automatic t_healthy();
    set_meas(0, 0, 0, 0);       strobe();
    chk("R2 none trip", trip, 0);
    chk("R9 mode 2oo4", mode, 0);
    set_meas(0, 0, 1500, 0);    strobe();
    chk("R2 single demand", trip, 0);
    set_meas(1200, 0, 0, 1000); strobe();
    chk("R2 two demands", trip, 1);
    set_meas(1100, 1100, 1100, 1100); strobe();
    chk("R2 four demands", trip, 1);
    set_meas(0, 0, 0, 0);       strobe();
    chk("R2 release all", trip, 0);
  endtask

  task automatic t_hysteresis();
    set_meas(1000, 1000, 0, 0); strobe();
    chk("R5 at setpoint", trip, 1);
    set_meas(980, 950, 0, 0);   strobe();
    chk("R6 inside band holds", trip, 1);
    set_meas(949, 949, 0, 0);   strobe();
    chk("R6 below release clears", trip, 0);
    set_meas(999, 999, 0, 0);   strobe();
    chk("R6 band holds clear", trip, 0);
    set_meas(2000, 2000, 0, 0);
    repeat (3) @(negedge clk);
    chk("R7 no strobe no change", trip, 0);
    strobe();
    chk("R7 strobe applies", trip, 1);
    set_meas(0, 0, 0, 0);       strobe();
    chk("R6 cleared again", trip, 0);
  endtask

  task automatic t_one_failed();
    pulse_flag(2);
    chk("R8 count after flag", fcnt, 1);
    repeat (3) @(negedge clk);
    chk("R8 latch sticky", fcnt, 1);
    set_meas(1500, 0, 1500, 0); strobe();
    chk("R3 failed vote ignored", trip, 0);
    chk("R9 mode 2oo3", mode, 1);
    set_meas(1500, 1500, 1500, 0); strobe();
    chk("R3 two healthy trip", trip, 1);
    set_meas(0, 0, 0, 0);       strobe();
    chk("R3 clear", trip, 0);
  endtask

  task automatic t_two_failed();
    pulse_flag(1);
    chk("R8 count two", fcnt, 2);
    strobe();
    chk("R4 forced trip", trip, 1);
    chk("R4 forced mode", mode, 2);
  endtask

  task automatic t_maint();
    flag[3] = 1'b1;
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    chk("R8 flag wins over clear", fcnt, 1);
    strobe();
    chk("R3 one left after clear", mode, 1);
    flag[3] = 1'b0;
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    chk("R8 clear empties", fcnt, 0);
    strobe();
    chk("R8 back to 2oo4", mode, 0);
    chk("R8 trip drops", trip, 0);
  endtask

  initial begin
    setp = {NCH{W'(1000)}};
    hyst = W'(50);
    repeat (3) @(negedge clk);
    t_reset();
    t_healthy();
    t_hysteresis();
    t_one_failed();
    t_two_failed();
    t_maint();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule